// File: doc/BRIEF.md
# Mode-Configurable Multiplexed Bus Port Controller

This block owns four 8-bit pin ports, called A, B, E and K. Three mode pins set its operating mode. The mode is captured on every clock while reset is high and then held until the next reset. In the single-chip and peripheral modes, every port is a general-purpose I/O port, driven by a data latch and a direction register. In the expanded modes, ports A and B carry a time-multiplexed external bus and two bits of port E carry its control. Each external cycle takes two clocks: an address phase followed by a data phase. The wide modes carry 16-bit data on A and B. The narrow modes carry 8-bit data on A only, and B keeps the low address byte.

An internal master reaches a small register bank through a simple bus: a write strobe, a 6-bit address and 8-bit data, with read data registered. The bank holds these registers:
- data and direction registers for each port;
- a port-E role byte;
- a mode register carrying a visibility enable;
- pull-up, drive-strength and bus-control bytes, which are storage only;
- an interrupt control byte.

The two active-low interrupt pins are synchronised and turned into request outputs.

Top module: `pbc_top`

## Requirements
- R1: During reset the mode is loaded from `mode_pins` on every clock. After reset it does not change. It reads back in bits [7:5] of the mode register (offset 0x0B). Encoding: 000 special single-chip, 001 emulation narrow, 010 special test, 011 emulation wide, 100 normal single-chip, 101 normal narrow, 110 special peripheral, 111 normal wide.
- R2: After reset the following hold:
  - all pin output enables and `reg_rdata` are 0;
  - both request outputs are 0;
  - the interrupt control byte reads 0x40.
- R3: The register offsets are:
  - A data 0x00, B data 0x01, A direction 0x02, B direction 0x03;
  - E data 0x08, E direction 0x09, E role 0x0A;
  - mode 0x0B, pull-up 0x0C, drive 0x0D, bus control 0x0E;
  - interrupt control 0x1E;
  - K data 0x32, K direction 0x33.

  Every other offset reads 0 and ignores writes. Read data appears on `reg_rdata` one clock after the address.
- R4: Outside the bus modes, each port drives its data latch on `*_out` and its direction register on `*_oe`. Both change one clock after the register write. Port K always works this way. A port data read returns the latch bit where direction is 1 and the pin bit where direction is 0.
- R5: In modes 011, 111 and 010, the bus phases alternate on every clock:
  - Address phase: A drives `ext_addr[15:8]` and B drives `ext_addr[7:0]`, all enabled.
  - Data phase of a write: A and B drive `ext_wdata`.
  - Data phase of a read: A and B are released, and `{pa_in,pb_in}` is captured into `ext_rdata` at the end of the phase.
- R6: In modes 001 and 101:
  - B keeps driving `ext_addr[7:0]` in the data phase.
  - A carries `ext_wdata[7:0]`, or is released on a read.
  - A read captures `{8'h00,pa_in}`.
- R7: In the bus modes, port E bit 4 is high in the data phase and bit 2 is high for a read. Both bits are enabled. The other E bits stay general-purpose. `bus_strobe` is high exactly in the data phase.
- R8: In modes 000, 100 and 110, no bus runs and `bus_strobe` stays low.
- R9: Mode register bit 3 is the visibility enable. Outside mode 010, only the first write after reset takes effect. In mode 010 every write takes effect.
- R10: `vis_en` equals the visibility bit only in modes 011, 111 and 001. In all other modes it stays 0.
- R11: `irq_n` passes through two synchronising flops. Interrupt control bit 6 enables the request. Bit 7 selects the detection type: 0 gives a level request while the pin is low, and 1 gives a one-clock pulse on a falling edge. `irq_req` rises on the third clock edge after the pin falls.
- R12: `xirq_n` is synchronised the same way. It is always level-sensitive and always enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pins | input | 3 | Mode selection, sampled during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ext_addr | input | 16 | External cycle address |
| ext_wdata | input | 16 | External cycle write data |
| ext_we | input | 1 | External cycle is a write |
| ext_rdata | output | 16 | Data captured by the last external read |
| bus_strobe | output | 1 | High during the data phase |
| vis_en | output | 1 | Effective visibility enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pe_in | input | 8 | Port E pin levels |
| pe_out | output | 8 | Port E drive values |
| pe_oe | output | 8 | Port E output enables |
| pk_in | input | 8 | Port K pin levels |
| pk_out | output | 8 | Port K drive values |
| pk_oe | output | 8 | Port K output enables |
| irq_n | input | 1 | Maskable interrupt pin, active low |
| xirq_n | input | 1 | Non-maskable interrupt pin, active low |
| irq_req | output | 1 | Synchronised maskable request |
| xirq_req | output | 1 | Synchronised non-maskable request |

## Verification
The assertions check several properties on every cycle:
- the latched mode never moves after reset;
- the phase flips on every clock in a bus mode and the strobe stays low otherwise;
- B stays enabled in the narrow data phase, and A is released in a wide read data phase;
- the visibility bit is frozen once locked outside test mode;
- an edge-mode request lasts one clock, and a disabled request stays low.

Some behaviours only the bench scenarios can show, because they need a reset in each mode and a known stimulus:
- the address and data values on the pins;
- the data captured from the pins on a read;
- mixed latch and pin read-back;
- reserved offsets;
- exact interrupt latency.

A behavioural model in the bench tracks ports A and B and the strobe on every clock.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [2:0] {
    M_SPC_SC   = 3'b000,
    M_EMU_NAR  = 3'b001,
    M_TEST     = 3'b010,
    M_EMU_WIDE = 3'b011,
    M_NRM_SC   = 3'b100,
    M_NRM_NAR  = 3'b101,
    M_PERIPH   = 3'b110,
    M_NRM_WIDE = 3'b111
  } mode_t;

  localparam int OFS_PA    = 'h00;
  localparam int OFS_PB    = 'h01;
  localparam int OFS_DDA   = 'h02;
  localparam int OFS_DDB   = 'h03;
  localparam int OFS_PE    = 'h08;
  localparam int OFS_DDE   = 'h09;
  localparam int OFS_EROLE = 'h0A;
  localparam int OFS_MODE  = 'h0B;
  localparam int OFS_PULL  = 'h0C;
  localparam int OFS_DRV   = 'h0D;
  localparam int OFS_BCTL  = 'h0E;
  localparam int OFS_ICTL  = 'h1E;
  localparam int OFS_PK    = 'h32;
  localparam int OFS_DDK   = 'h33;

  localparam int PE_STB_BIT = 4;
  localparam int PE_RD_BIT  = 2;

  function automatic logic is_wide(mode_t m);
    return (m == M_TEST) || (m == M_EMU_WIDE) || (m == M_NRM_WIDE);
  endfunction

  function automatic logic is_narrow(mode_t m);
    return (m == M_EMU_NAR) || (m == M_NRM_NAR);
  endfunction

  function automatic logic vis_allowed(mode_t m);
    return (m == M_EMU_WIDE) || (m == M_NRM_WIDE) || (m == M_EMU_NAR);
  endfunction

endpackage

// File: rtl/pbc_regfile.sv
module pbc_regfile
  import pbc_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode_pins,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  pa_in,
  input  logic [W-1:0]  pb_in,
  input  logic [W-1:0]  pe_in,
  input  logic [W-1:0]  pk_in,
  output mode_t         mode,
  output logic [W-1:0]  pa_lat,
  output logic [W-1:0]  pb_lat,
  output logic [W-1:0]  dda,
  output logic [W-1:0]  ddb,
  output logic [W-1:0]  pe_lat,
  output logic [W-1:0]  dde,
  output logic [W-1:0]  pk_lat,
  output logic [W-1:0]  ddk,
  output logic          irq_edge,
  output logic          irq_en,
  output logic          ivis
);

  localparam logic [W-1:0] ICTL_RST = W'(8'h40);

  logic [W-1:0] erole, pull, drv, bctl, ictl, rd_nx;
  logic         locked;

  function automatic logic [W-1:0] mix(logic [W-1:0] lat, logic [W-1:0] dir, logic [W-1:0] pin);
    return (lat & dir) | (pin & ~dir);
  endfunction

  assign irq_edge = ictl[7];
  assign irq_en   = ictl[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= mode_t'(mode_pins);
      pa_lat <= '0; pb_lat <= '0; dda <= '0; ddb <= '0;
      pe_lat <= '0; dde <= '0; pk_lat <= '0; ddk <= '0;
      erole  <= '0; pull <= '0; drv <= '0; bctl <= '0;
      ictl   <= ICTL_RST;
      ivis   <= 1'b0;
      locked <= 1'b0;
    end else if (wr) begin
      case (addr)
        AW'(OFS_PA):    pa_lat <= wdata;
        AW'(OFS_PB):    pb_lat <= wdata;
        AW'(OFS_DDA):   dda    <= wdata;
        AW'(OFS_DDB):   ddb    <= wdata;
        AW'(OFS_PE):    pe_lat <= wdata;
        AW'(OFS_DDE):   dde    <= wdata;
        AW'(OFS_EROLE): erole  <= wdata;
        AW'(OFS_MODE): begin
          if (!locked || mode == M_TEST) ivis <= wdata[3];
          locked <= 1'b1;
        end
        AW'(OFS_PULL):  pull   <= wdata;
        AW'(OFS_DRV):   drv    <= wdata;
        AW'(OFS_BCTL):  bctl   <= wdata;
        AW'(OFS_ICTL):  ictl   <= wdata;
        AW'(OFS_PK):    pk_lat <= wdata;
        AW'(OFS_DDK):   ddk    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_nx = '0;
    case (addr)
      AW'(OFS_PA):    rd_nx = mix(pa_lat, dda, pa_in);
      AW'(OFS_PB):    rd_nx = mix(pb_lat, ddb, pb_in);
      AW'(OFS_DDA):   rd_nx = dda;
      AW'(OFS_DDB):   rd_nx = ddb;
      AW'(OFS_PE):    rd_nx = mix(pe_lat, dde, pe_in);
      AW'(OFS_DDE):   rd_nx = dde;
      AW'(OFS_EROLE): rd_nx = erole;
      AW'(OFS_MODE):  rd_nx = W'({mode, 1'b0, ivis, 3'b000});
      AW'(OFS_PULL):  rd_nx = pull;
      AW'(OFS_DRV):   rd_nx = drv;
      AW'(OFS_BCTL):  rd_nx = bctl;
      AW'(OFS_ICTL):  rd_nx = ictl;
      AW'(OFS_PK):    rd_nx = mix(pk_lat, ddk, pk_in);
      AW'(OFS_DDK):   rd_nx = ddk;
      default:        rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end

  // R1: mode frozen once reset is released
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode));

  // R9: visibility bit frozen after first write outside test mode
  p_mode_once_r9: assert property (@(posedge clk) disable iff (rst)
    (locked && mode != M_TEST) |=> $stable(ivis));

endmodule

// File: rtl/pbc_pin_sync.sv
module pbc_pin_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] en,
  output logic [N-1:0] req
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1     <= 1'b1;
        s2     <= 1'b1;
        s3     <= 1'b1;
        req[i] <= 1'b0;
      end else begin
        s1     <= pin_n[i];
        s2     <= s1;
        s3     <= s2;
        req[i] <= en[i] & (edge_sel[i] ? (s3 & ~s2) : ~s2);
      end
    end

    // R11: an edge request lasts exactly one clock
    p_edge_pulse_r11: assert property (@(posedge clk) disable iff (rst)
      (req[i] && edge_sel[i]) |=> !req[i]);

    // R11: a disabled request stays low
    p_req_off_r11: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> !req[i]);
  end

endmodule

// File: rtl/pbc_bus_mux.sv
module pbc_bus_mux
  import pbc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  mode_t          mode,
  input  logic [W-1:0]   pa_lat,
  input  logic [W-1:0]   dda,
  input  logic [W-1:0]   pb_lat,
  input  logic [W-1:0]   ddb,
  input  logic [W-1:0]   pe_lat,
  input  logic [W-1:0]   dde,
  input  logic [W-1:0]   pa_in,
  input  logic [W-1:0]   pb_in,
  input  logic [2*W-1:0] ext_addr,
  input  logic [2*W-1:0] ext_wdata,
  input  logic           ext_we,
  output logic [2*W-1:0] ext_rdata,
  output logic           strobe,
  output logic [W-1:0]   pa_out,
  output logic [W-1:0]   pa_oe,
  output logic [W-1:0]   pb_out,
  output logic [W-1:0]   pb_oe,
  output logic [W-1:0]   pe_out,
  output logic [W-1:0]   pe_oe
);

  localparam logic [W-1:0] CTL_MASK = W'((1 << PE_STB_BIT) | (1 << PE_RD_BIT));

  logic           wide, narrow, expd, phase_q, nphase, rd_flag;
  logic           cyc_we;
  logic [2*W-1:0] cyc_addr, cyc_wd;

  assign wide    = is_wide(mode);
  assign narrow  = is_narrow(mode);
  assign expd    = wide | narrow;
  assign nphase  = expd ? ~phase_q : phase_q;
  assign rd_flag = nphase ? ~cyc_we : ~ext_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= 1'b1;
      strobe    <= 1'b0;
      cyc_we    <= 1'b0;
      cyc_addr  <= '0;
      cyc_wd    <= '0;
      ext_rdata <= '0;
      pa_out <= '0; pa_oe <= '0; pb_out <= '0; pb_oe <= '0;
      pe_out <= '0; pe_oe <= '0;
    end else begin
      phase_q <= nphase;
      strobe  <= expd & nphase;
      if (expd && strobe && !cyc_we)
        ext_rdata <= wide ? {pa_in, pb_in} : {{W{1'b0}}, pa_in};
      if (!expd) begin
        pa_out <= pa_lat; pa_oe <= dda;
        pb_out <= pb_lat; pb_oe <= ddb;
        pe_out <= pe_lat; pe_oe <= dde;
      end else begin
        pe_oe  <= dde | CTL_MASK;
        pe_out <= pe_lat;
        pe_out[PE_STB_BIT] <= nphase;
        pe_out[PE_RD_BIT]  <= rd_flag;
        if (!nphase) begin
          cyc_we   <= ext_we;
          cyc_addr <= ext_addr;
          cyc_wd   <= ext_wdata;
          pa_out   <= ext_addr[2*W-1:W];
          pb_out   <= ext_addr[W-1:0];
          pa_oe    <= '1;
          pb_oe    <= '1;
        end else if (wide) begin
          pa_out <= cyc_wd[2*W-1:W];
          pb_out <= cyc_wd[W-1:0];
          pa_oe  <= {W{cyc_we}};
          pb_oe  <= {W{cyc_we}};
        end else begin
          pa_out <= cyc_wd[W-1:0];
          pa_oe  <= {W{cyc_we}};
          pb_out <= cyc_addr[W-1:0];
          pb_oe  <= '1;
        end
      end
    end
  end

  // R5: phases alternate on every clock in a bus mode
  p_phase_alt_r5: assert property (@(posedge clk) disable iff (rst)
    expd |=> (phase_q != $past(phase_q)));

  // R5: port A released during a wide read data phase
  p_wide_float_r5: assert property (@(posedge clk) disable iff (rst)
    (wide && strobe && !cyc_we) |-> (pa_oe == '0));

  // R6: port B keeps driving in the narrow data phase
  p_narrow_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (narrow && strobe) |-> (pb_oe == '1));

  // R8: no strobe without a bus
  p_no_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !expd |-> !strobe);

endmodule

// File: rtl/pbc_top.sv
module pbc_top
  import pbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  mode_pins,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] ext_addr,
  input  logic [15:0] ext_wdata,
  input  logic        ext_we,
  output logic [15:0] ext_rdata,
  output logic        bus_strobe,
  output logic        vis_en,
  input  logic [7:0]  pa_in,
  output logic [7:0]  pa_out,
  output logic [7:0]  pa_oe,
  input  logic [7:0]  pb_in,
  output logic [7:0]  pb_out,
  output logic [7:0]  pb_oe,
  input  logic [7:0]  pe_in,
  output logic [7:0]  pe_out,
  output logic [7:0]  pe_oe,
  input  logic [7:0]  pk_in,
  output logic [7:0]  pk_out,
  output logic [7:0]  pk_oe,
  input  logic        irq_n,
  input  logic        xirq_n,
  output logic        irq_req,
  output logic        xirq_req
);

  localparam int W  = 8;
  localparam int AW = 6;

  mode_t        mode;
  logic [W-1:0] pa_lat, pb_lat, dda, ddb, pe_lat, dde, pk_lat, ddk;
  logic         irq_edge, irq_en, ivis;
  logic [1:0]   req;

  pbc_regfile #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .mode_pins(mode_pins),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .pa_in(pa_in), .pb_in(pb_in), .pe_in(pe_in), .pk_in(pk_in),
    .mode(mode), .pa_lat(pa_lat), .pb_lat(pb_lat), .dda(dda), .ddb(ddb),
    .pe_lat(pe_lat), .dde(dde), .pk_lat(pk_lat), .ddk(ddk),
    .irq_edge(irq_edge), .irq_en(irq_en), .ivis(ivis)
  );

  pbc_bus_mux #(.W(W)) u_bus (
    .clk(clk), .rst(rst), .mode(mode),
    .pa_lat(pa_lat), .dda(dda), .pb_lat(pb_lat), .ddb(ddb),
    .pe_lat(pe_lat), .dde(dde), .pa_in(pa_in), .pb_in(pb_in),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we),
    .ext_rdata(ext_rdata), .strobe(bus_strobe),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pe_out(pe_out), .pe_oe(pe_oe)
  );

  pbc_pin_sync #(.N(2)) u_sync (
    .clk(clk), .rst(rst),
    .pin_n({xirq_n, irq_n}),
    .edge_sel({1'b0, irq_edge}),
    .en({1'b1, irq_en}),
    .req(req)
  );

  assign irq_req  = req[0];
  assign xirq_req = req[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pk_out <= '0;
      pk_oe  <= '0;
      vis_en <= 1'b0;
    end else begin
      pk_out <= pk_lat;
      pk_oe  <= ddk;
      vis_en <= ivis & vis_allowed(mode);
    end
  end

endmodule

// File: tb/tb_pbc_top.sv
module tb_pbc_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_pins = 3'b100;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] ext_addr = '0, ext_wdata = '0;
  logic        ext_we = 1'b0;
  logic [15:0] ext_rdata;
  logic        bus_strobe, vis_en;
  logic [7:0]  pa_in = '0, pb_in = '0, pe_in = '0, pk_in = '0;
  logic [7:0]  pa_out, pa_oe, pb_out, pb_oe, pe_out, pe_oe, pk_out, pk_oe;
  logic        irq_n = 1'b1, xirq_n = 1'b1;
  logic        irq_req, xirq_req;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  pbc_top dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference for ports A/B and strobe
  logic       m_ok = 1'b0;
  logic [2:0] m_mode;
  logic       m_ph, m_cwe;
  logic [15:0] m_caddr, m_cwd;
  logic [7:0] m_pa, m_pb, m_da, m_db;
  logic [7:0] e_pa, e_paoe, e_pb, e_pboe;
  logic       e_stb;

  always @(posedge clk) begin
    logic wide, nar, np;
    if (rst) begin
      m_ok = 1'b1; m_mode = mode_pins; m_ph = 1'b1; e_stb = 1'b0;
      e_pa = 0; e_paoe = 0; e_pb = 0; e_pboe = 0;
      m_pa = 0; m_pb = 0; m_da = 0; m_db = 0;
      m_cwe = 0; m_caddr = 0; m_cwd = 0;
    end else begin
      wide = (m_mode == 3'b010) || (m_mode == 3'b011) || (m_mode == 3'b111);
      nar  = (m_mode == 3'b001) || (m_mode == 3'b101);
      np   = (wide || nar) ? !m_ph : m_ph;
      if (!(wide || nar)) begin
        e_pa = m_pa; e_paoe = m_da; e_pb = m_pb; e_pboe = m_db;
      end else if (!np) begin
        e_pa = ext_addr[15:8]; e_pb = ext_addr[7:0]; e_paoe = 8'hFF; e_pboe = 8'hFF;
        m_cwe = ext_we; m_caddr = ext_addr; m_cwd = ext_wdata;
      end else if (wide) begin
        e_pa = m_cwd[15:8]; e_pb = m_cwd[7:0];
        e_paoe = {8{m_cwe}}; e_pboe = {8{m_cwe}};
      end else begin
        e_pa = m_cwd[7:0]; e_paoe = {8{m_cwe}};
        e_pb = m_caddr[7:0]; e_pboe = 8'hFF;
      end
      e_stb = (wide || nar) && np;
      m_ph  = np;
      if (reg_wr) begin
        case (reg_addr)
          6'h00: m_pa = reg_wdata;
          6'h01: m_pb = reg_wdata;
          6'h02: m_da = reg_wdata;
          6'h03: m_db = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (m_ok) begin
      chk("R5 R6 R8 model strobe", {31'd0, bus_strobe}, {31'd0, e_stb});
      chk("R4 R5 R6 model A", {pa_out, pa_oe}, {e_pa, e_paoe});
      chk("R4 R5 R6 model B", {pb_out, pb_oe}, {e_pb, e_pboe});
    end
  end

  // ---------------- stimulus helpers
  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst = 1'b1; mode_pins = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mode_pins = ~m;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic to_addr_phase();
    do @(negedge clk); while (bus_strobe !== 1'b0);
  endtask

  task automatic irq_probe(input logic e1, input logic e2, input logic e3, input string tag);
    irq_n = 1'b0;
    @(negedge clk);
    @(negedge clk); chk(tag, {31'd0, irq_req}, {31'd0, e1});
    @(negedge clk); chk(tag, {31'd0, irq_req}, {31'd0, e2});
    @(negedge clk); chk(tag, {31'd0, irq_req}, {31'd0, e3});
    irq_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // ---------------- scenarios
  initial begin
    // normal single-chip
    do_reset(3'b100);
    chk("R2 reset A oe", {24'd0, pa_oe}, 0);
    chk("R2 reset K oe", {24'd0, pk_oe}, 0);
    chk("R2 reset rdata", {24'd0, reg_rdata}, 0);
    chk("R2 reset req", {30'd0, irq_req, xirq_req}, 0);
    rd(6'h1E, rv); chk("R2 ictl reset", {24'd0, rv}, 32'h40);
    rd(6'h0B, rv); chk("R1 mode readback", {24'd0, rv}, 32'h80);

    wr(6'h02, 8'hF0); wr(6'h00, 8'hA5);
    @(negedge clk);
    chk("R4 A drive", {16'd0, pa_out, pa_oe}, 32'hA5F0);
    pa_in = 8'h3C;
    rd(6'h00, rv); chk("R4 A mixed read", {24'd0, rv}, 32'hAC);
    wr(6'h32, 8'h5A); wr(6'h33, 8'hFF);
    @(negedge clk);
    chk("R4 K drive", {16'd0, pk_out, pk_oe}, 32'h5AFF);
    chk("R8 E no control", {24'd0, pe_oe}, 0);

    wr(6'h04, 8'hFF);
    rd(6'h04, rv); chk("R3 reserved reads 0", {24'd0, rv}, 0);
    wr(6'h10, 8'h77);
    rd(6'h00, rv); chk("R3 reserved write ignored", {24'd0, rv}, 32'hAC);
    wr(6'h0C, 8'h33); rd(6'h0C, rv); chk("R3 pull", {24'd0, rv}, 32'h33);
    wr(6'h0D, 8'h44); rd(6'h0D, rv); chk("R3 drive", {24'd0, rv}, 32'h44);
    wr(6'h0E, 8'h55); rd(6'h0E, rv); chk("R3 bus ctl", {24'd0, rv}, 32'h55);
    wr(6'h0A, 8'h66); rd(6'h0A, rv); chk("R3 E role", {24'd0, rv}, 32'h66);

    wr(6'h0B, 8'h08); rd(6'h0B, rv); chk("R9 first mode write", {24'd0, rv}, 32'h88);
    wr(6'h0B, 8'h00); rd(6'h0B, rv); chk("R9 later write ignored", {24'd0, rv}, 32'h88);
    @(negedge clk); chk("R10 vis off single-chip", {31'd0, vis_en}, 0);
    chk("R1 mode held", {24'd0, rv}, 32'h88);

    irq_probe(1'b0, 1'b1, 1'b1, "R11 level");
    wr(6'h1E, 8'hC0);
    irq_probe(1'b0, 1'b1, 1'b0, "R11 edge");
    wr(6'h1E, 8'h00);
    irq_probe(1'b0, 1'b0, 1'b0, "R11 disabled");
    xirq_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 xirq latency", {31'd0, xirq_req}, 0);
    @(negedge clk); chk("R12 xirq level", {31'd0, xirq_req}, 1);
    xirq_n = 1'b1;
    repeat (4) @(negedge clk);

    // normal wide
    ext_addr = 16'h1234; ext_wdata = 16'hABCD; ext_we = 1'b1;
    do_reset(3'b111);
    repeat (3) @(negedge clk);
    to_addr_phase();
    chk("R5 wide address", {16'd0, pa_out, pb_out}, 32'h1234);
    chk("R7 E addr phase", {30'd0, pe_out[4], pe_out[2]}, 0);
    chk("R7 E control oe", {24'd0, pe_oe}, 32'h14);
    @(negedge clk);
    chk("R5 wide write data", {16'd0, pa_out, pb_out}, 32'hABCD);
    chk("R7 E data phase", {30'd0, pe_out[4], pe_out[2]}, 32'h2);
    ext_we = 1'b0; pa_in = 8'h9A; pb_in = 8'hBC;
    repeat (6) @(negedge clk);
    chk("R5 wide read capture", {16'd0, ext_rdata}, 32'h9ABC);
    to_addr_phase(); @(negedge clk);
    chk("R5 wide read release", {16'd0, pa_oe, pb_oe}, 0);
    chk("R7 E read flag", {31'd0, pe_out[2]}, 1);
    wr(6'h0B, 8'h08); @(negedge clk);
    chk("R10 vis on wide", {31'd0, vis_en}, 1);
    rd(6'h0B, rv); chk("R1 wide mode read", {24'd0, rv}, 32'hE8);

    // normal narrow
    ext_addr = 16'h5678; ext_wdata = 16'h00EF; ext_we = 1'b1;
    do_reset(3'b101);
    repeat (3) @(negedge clk);
    to_addr_phase();
    chk("R6 narrow address", {16'd0, pa_out, pb_out}, 32'h5678);
    @(negedge clk);
    chk("R6 narrow write data", {16'd0, pa_out, pb_out}, 32'hEF78);
    ext_we = 1'b0; pa_in = 8'h77;
    repeat (6) @(negedge clk);
    chk("R6 narrow read capture", {16'd0, ext_rdata}, 32'h0077);
    wr(6'h0B, 8'h08); @(negedge clk);
    chk("R10 vis off normal narrow", {31'd0, vis_en}, 0);

    // special test
    do_reset(3'b010);
    wr(6'h0B, 8'h08); rd(6'h0B, rv); chk("R9 test first write", {24'd0, rv}, 32'h48);
    wr(6'h0B, 8'h00); rd(6'h0B, rv); chk("R9 test rewrite", {24'd0, rv}, 32'h40);
    repeat (4) @(negedge clk);

    // special peripheral
    do_reset(3'b110);
    wr(6'h03, 8'h0F); wr(6'h01, 8'h99);
    repeat (4) @(negedge clk);
    chk("R8 peripheral GPIO", {16'd0, pb_out, pb_oe}, 32'h990F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule